// File: doc/BRIEF.md
# Masked vector execution unit

This block runs one arithmetic operation element by element over two vector register operands. A per-element mask gates which results are written back. It has a single lane. Elements are taken one per cycle. The vector register file sits outside the block: the block drives a read port that selects two source registers and one element index, and it receives the two element values in the same cycle. Results leave through a write port that carries a register, an element index and data.

The mask is held inside the block and set to all ones at reset. Three compare operations rebuild the mask from register contents, and a complement operation inverts the whole mask. Together these let an if/else be done as two masked moves.

Arithmetic operations run in one of two modes, chosen at start:
- **Simple mode** steps through every element up to the vector length and suppresses writeback where the mask bit is clear.
- **Density-time mode** first spends one cycle scanning the mask. It then issues only the enabled elements, so its cycle count follows the number of set mask bits rather than the length.

Top module: `mvx_unit`

## Requirements
- R1: After reset, done_o and wr_en_o are low and every mask bit is one.
- R2: An operation is accepted on the clock edge where start_i is high and the unit is idle. done_o is high for exactly one cycle at the end of each operation. Outside an operation, wr_en_o and done_o stay low.
- R3: Simple mode with length L processes element i (i = 0..L-1) in the i-th cycle after acceptance, in ascending order. It writes element i only when mask bit i is one, and done_o follows in cycle L.
- R4: Density-time mode spends cycle 0 scanning, writing nothing. It then writes only the elements whose mask bit is one and whose index is below L, one per cycle in ascending index order. done_o follows in the cycle after the last write.
- R5: Density-time mode with no enabled element raises done_o in the cycle after the scan cycle and writes nothing.
- R6: The arithmetic opcodes on op_i are:
  - 0: a+b
  - 1: a-b
  - 2: the low DATA_W bits of a*b
  - 3: a shifted right by one, logically
  - 4: a, as a move

  All results are unsigned and modulo 2^DATA_W, written to register vd_i.
- R7: The compare opcodes are:
  - 8: mask[i] = (a[i] == 0)
  - 9: mask[i] = (a[i] != 0)
  - 10: mask[i] = (a[i] >= b[i]), unsigned

  They run one element per cycle for i below L in either mode, perform no register writes, leave mask bits at index L or above unchanged, and raise done_o in cycle L.
- R8: Opcode 12 inverts every mask bit and raises done_o in cycle 0.
- R9: Mask bits at index L or above never cause a write, in either mode.
- R10: A length of zero, or any opcode outside the lists above, completes with done_o in cycle 0 and no writes. A vlen_i above N_ELEM is treated as N_ELEM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| op_i | input | 4 | Opcode |
| mode_i | input | 1 | 0 simple, 1 density-time (arithmetic only) |
| vlen_i | input | IDX_W+1 | Vector length |
| vd_i | input | RA_W | Destination register |
| va_i | input | RA_W | First source register |
| vb_i | input | RA_W | Second source register |
| rd_a_reg_o | output | RA_W | Read port register A |
| rd_b_reg_o | output | RA_W | Read port register B |
| rd_idx_o | output | IDX_W | Read element index |
| rd_a_data_i | input | DATA_W | Element of register A |
| rd_b_data_i | input | DATA_W | Element of register B |
| wr_en_o | output | 1 | Element write enable |
| wr_reg_o | output | RA_W | Write register |
| wr_idx_o | output | IDX_W | Write element index |
| wr_data_o | output | DATA_W | Write data |
| done_o | output | 1 | Operation complete pulse |

## Verification
The bench builds the unit with its defaults: eight elements, 16-bit data and eight registers. This makes the length field four bits wide, so lengths above the element count can be driven to exercise clamping. Eight elements are enough to hold masks with scattered gaps, fully clear or set masks, and masks whose set bits lie only above a short length. A cycle-by-cycle model of timing, writes and mask state is compared against the ports on every clock, and the whole register file is compared against the model at the end.

// File: rtl/mvx_pkg.sv
package mvx_pkg;
  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_MUL = 4'd2;
  localparam logic [3:0] OP_SHR = 4'd3;
  localparam logic [3:0] OP_MOV = 4'd4;
  localparam logic [3:0] OP_EQZ = 4'd8;
  localparam logic [3:0] OP_NEZ = 4'd9;
  localparam logic [3:0] OP_GE  = 4'd10;
  localparam logic [3:0] OP_NOT = 4'd12;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_RUN, ST_DONE} mvx_st_e;

  function automatic logic op_is_arith(logic [3:0] op);
    return op <= OP_MOV;
  endfunction

  function automatic logic op_is_cmp(logic [3:0] op);
    return (op == OP_EQZ) || (op == OP_NEZ) || (op == OP_GE);
  endfunction
endpackage

// File: rtl/mvx_alu.sv
module mvx_alu import mvx_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cond_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      OP_SHR:  res_o = a_i >> 1;
      OP_MOV:  res_o = a_i;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_EQZ:  cond_o = (a_i == '0);
      OP_NEZ:  cond_o = (a_i != '0);
      OP_GE:   cond_o = (a_i >= b_i);
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mvx_mask.sv
module mvx_mask #(
  parameter int N_ELEM = 8,
  parameter int IDX_W  = 3,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic              set_val_i,
  input  logic              inv_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [N_ELEM-1:0] mask_o,
  output logic [N_ELEM-1:0] en_o
);
  logic [N_ELEM-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '1;
    else if (inv_i)  mask_q <= ~mask_q;
    else if (set_i)  mask_q[set_idx_i] <= set_val_i;
  end

  // element enable: mask bit and index inside the active length
  for (genvar g = 0; g < N_ELEM; g++) begin : g_en
    assign en_o[g] = mask_q[g] & (len_i > LEN_W'(g));
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/mvx_pick.sv
module mvx_pick #(
  parameter int N_ELEM = 8,
  parameter int IDX_W  = 3
) (
  input  logic [N_ELEM-1:0] vec_i,
  output logic [IDX_W-1:0]  idx_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N_ELEM - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mvx_unit.sv
module mvx_unit import mvx_pkg::*; #(
  parameter int  N_ELEM = 8,
  parameter int  DATA_W = 16,
  parameter int  NREG   = 8,
  localparam int IDX_W  = $clog2(N_ELEM),
  localparam int LEN_W  = IDX_W + 1,
  localparam int RA_W   = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic              mode_i,
  input  logic [LEN_W-1:0]  vlen_i,
  input  logic [RA_W-1:0]   vd_i,
  input  logic [RA_W-1:0]   va_i,
  input  logic [RA_W-1:0]   vb_i,
  output logic [RA_W-1:0]   rd_a_reg_o,
  output logic [RA_W-1:0]   rd_b_reg_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_a_data_i,
  input  logic [DATA_W-1:0] rd_b_data_i,
  output logic              wr_en_o,
  output logic [RA_W-1:0]   wr_reg_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o
);
  mvx_st_e           st_q;
  logic [3:0]        op_q;
  logic              dens_q, arith_q, cmp_q;
  logic [RA_W-1:0]   vd_q, va_q, vb_q;
  logic [LEN_W-1:0]  len_q, len_in;
  logic [IDX_W-1:0]  idx_q, pick_idx, cur_idx;
  logic [N_ELEM-1:0] pend_q, rest, en, mask_q;
  logic              arith_in, cmp_in, run, inv, cmp_val, last;

  assign len_in   = (vlen_i > LEN_W'(N_ELEM)) ? LEN_W'(N_ELEM) : vlen_i;
  assign arith_in = op_is_arith(op_i);
  assign cmp_in   = op_is_cmp(op_i);
  assign run      = (st_q == ST_RUN);
  assign inv      = (st_q == ST_IDLE) && start_i && (op_i == OP_NOT);
  assign cur_idx  = dens_q ? pick_idx : idx_q;
  assign rest     = pend_q & ~(N_ELEM'(1) << pick_idx);
  assign last     = ({1'b0, idx_q} == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= '0;
      dens_q  <= 1'b0;
      arith_q <= 1'b0;
      cmp_q   <= 1'b0;
      vd_q    <= '0;
      va_q    <= '0;
      vb_q    <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      pend_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          op_q    <= op_i;
          arith_q <= arith_in;
          cmp_q   <= cmp_in;
          dens_q  <= mode_i & arith_in;
          vd_q    <= vd_i;
          va_q    <= va_i;
          vb_q    <= vb_i;
          len_q   <= len_in;
          idx_q   <= '0;
          if (len_in == '0 || !(arith_in || cmp_in)) st_q <= ST_DONE;
          else if (mode_i && arith_in)               st_q <= ST_SCAN;
          else                                       st_q <= ST_RUN;
        end
        ST_SCAN: begin
          pend_q <= en;
          st_q   <= (|en) ? ST_RUN : ST_DONE;
        end
        ST_RUN: begin
          if (dens_q) begin
            pend_q <= rest;
            if (rest == '0) st_q <= ST_DONE;
          end else if (last) begin
            st_q <= ST_DONE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  mvx_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op_q),
    .a_i   (rd_a_data_i),
    .b_i   (rd_b_data_i),
    .res_o (wr_data_o),
    .cond_o(cmp_val)
  );

  mvx_mask #(.N_ELEM(N_ELEM), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (run && cmp_q),
    .set_idx_i(idx_q),
    .set_val_i(cmp_val),
    .inv_i    (inv),
    .len_i    (len_q),
    .mask_o   (mask_q),
    .en_o     (en)
  );

  mvx_pick #(.N_ELEM(N_ELEM), .IDX_W(IDX_W)) u_pick (
    .vec_i(pend_q),
    .idx_o(pick_idx)
  );

  assign rd_a_reg_o = va_q;
  assign rd_b_reg_o = vb_q;
  assign rd_idx_o   = cur_idx;
  assign wr_reg_o   = vd_q;
  assign wr_idx_o   = cur_idx;
  assign wr_en_o    = run && arith_q && (dens_q || en[cur_idx]);
  assign done_o     = (st_q == ST_DONE);
endmodule

// File: rtl/mvx_unit_chk.sv
module mvx_unit_chk #(
  parameter int N_ELEM = 8,
  parameter int IDX_W  = 3,
  parameter int LEN_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic              done_i,
  input logic              run_i,
  input logic              dens_i,
  input logic              cmp_i,
  input logic [LEN_W-1:0]  len_i,
  input logic [N_ELEM-1:0] mask_i
);
  // R3
  wr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> mask_i[wr_idx_i]);

  // R9
  wr_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ({1'b0, wr_idx_i} < len_i));

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R3
  simple_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !dens_i && $past(run_i)) |-> (rd_idx_i == IDX_W'($past(rd_idx_i) + 1'b1)));

  // R4
  dens_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && dens_i && $past(wr_en_i)) |-> (wr_idx_i > $past(wr_idx_i)));

  // R7
  cmp_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cmp_i) |-> !wr_en_i);
endmodule

bind mvx_unit mvx_unit_chk #(.N_ELEM(N_ELEM), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_o),
  .wr_idx_i(wr_idx_o),
  .rd_idx_i(rd_idx_o),
  .done_i  (done_o),
  .run_i   (run),
  .dens_i  (dens_q),
  .cmp_i   (cmp_q),
  .len_i   (len_q),
  .mask_i  (mask_q)
);

// File: tb/tb_mvx_unit.sv
`timescale 1ns/1ps
module tb_mvx_unit;
  localparam int N = 8, DW = 16, NR = 8, IW = 3, LW = 4, RW = 3;

  typedef struct {
    logic          we;
    logic [IW-1:0] idx;
    logic [DW-1:0] data;
    logic          done;
    string         req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0;
  logic [3:0] op = '0;
  logic [LW-1:0] vlen = '0;
  logic [RW-1:0] vd = '0, va = '0, vb = '0;
  logic [RW-1:0] rd_a_reg, rd_b_reg, wr_reg;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic wr_en, done;

  logic [DW-1:0] rf  [NR][N];
  logic [DW-1:0] mrf [NR][N];
  logic [N-1:0]  mmask;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic chk_en = 1'b0;

  always #2.5 clk = ~clk;

  mvx_unit #(.N_ELEM(N), .DATA_W(DW), .NREG(NR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .mode_i(mode),
    .vlen_i(vlen), .vd_i(vd), .va_i(va), .vb_i(vb),
    .rd_a_reg_o(rd_a_reg), .rd_b_reg_o(rd_b_reg), .rd_idx_o(rd_idx),
    .rd_a_data_i(rd_a_data), .rd_b_data_i(rd_b_data),
    .wr_en_o(wr_en), .wr_reg_o(wr_reg), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .done_o(done)
  );

  assign rd_a_data = rf[rd_a_reg][rd_idx];
  assign rd_b_data = rf[rd_b_reg][rd_idx];

  always @(posedge clk) if (wr_en) rf[wr_reg][wr_idx] <= wr_data;

  task automatic push(logic we, int idx, logic [DW-1:0] data, logic dn, string req);
    exp_t e;
    e.we = we; e.idx = IW'(idx); e.data = data; e.done = dn; e.req = req;
    q.push_back(e);
  endtask

  // per-cycle comparison against the model stream
  always @(negedge clk) begin
    if (chk_en) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else begin e.we = 0; e.idx = '0; e.data = '0; e.done = 0; e.req = "R2"; end
      checks++;
      if (wr_en !== e.we || done !== e.done ||
          (e.we && (wr_idx !== e.idx || wr_data !== e.data))) begin
        fails++;
        $display("FAIL %s: we=%b idx=%0d data=%h done=%b expected we=%b idx=%0d data=%h done=%b",
                 e.req, wr_en, wr_idx, wr_data, done, e.we, e.idx, e.data, e.done);
      end
    end
  end

  function automatic logic [DW-1:0] calc(logic [3:0] o, logic [DW-1:0] a, logic [DW-1:0] b);
    case (o)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a * b;
      4'd3: return a >> 1;
      default: return a;
    endcase
  endfunction

  task automatic run_op(logic [3:0] o, logic m, int d, int a, int b, int l, string req);
    int len;
    logic [DW-1:0] x, y;
    @(posedge clk); #1;
    op = o; mode = m; vd = RW'(d); va = RW'(a); vb = RW'(b); vlen = LW'(l); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    len = (l > N) ? N : l;
    if (o == 4'd12) begin
      mmask = ~mmask;
      push(0, 0, '0, 1, req);
    end else if (len == 0 || !(o <= 4'd4 || (o >= 4'd8 && o <= 4'd10))) begin
      push(0, 0, '0, 1, req);
    end else if (o >= 4'd8) begin
      for (int i = 0; i < len; i++) begin
        x = mrf[a][i]; y = mrf[b][i];
        push(0, 0, '0, 0, req);
        mmask[i] = (o == 4'd8) ? (x == 0) : (o == 4'd9) ? (x != 0) : (x >= y);
      end
      push(0, 0, '0, 1, req);
    end else begin
      if (m) push(0, 0, '0, 0, req);
      for (int i = 0; i < len; i++) begin
        if (mmask[i]) begin
          x = calc(o, mrf[a][i], mrf[b][i]);
          push(1, i, x, 0, req);
          mrf[d][i] = x;
        end else if (!m) push(0, 0, '0, 0, req);
      end
      push(0, 0, '0, 1, req);
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < N; i++) begin
        logic [DW-1:0] v;
        case (r)
          0: v = DW'(i * 7 + 2);
          1: v = DW'(20 - i * 3);
          3: v = (i % 3 == 0) ? '0 : DW'(i + 5);
          6: v = '0;
          default: v = DW'(r * 100 + i);
        endcase
        rf[r][i] = v; mrf[r][i] = v;
      end
    mmask = '1;

    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (done !== 1'b0 || wr_en !== 1'b0) begin
      fails++;
      $display("FAIL R1: done=%b we=%b expected done=0 we=0", done, wr_en);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    chk_en = 1'b1;

    run_op(4'd0, 0, 2, 0, 1, 8, "R1");   // full mask after reset
    run_op(4'd9, 0, 0, 3, 0, 8, "R7");   // mask = v3 != 0
    run_op(4'd2, 0, 4, 0, 1, 8, "R3");   // simple masked mul
    run_op(4'd1, 1, 5, 0, 1, 8, "R4");   // density sub
    run_op(4'd12, 0, 0, 0, 0, 8, "R8");
    run_op(4'd3, 1, 5, 0, 1, 8, "R6");   // density shift on complement
    run_op(4'd10, 1, 0, 0, 1, 8, "R7");  // a >= b, mode ignored
    run_op(4'd4, 0, 7, 0, 0, 8, "R6");   // move where a >= b
    run_op(4'd12, 0, 0, 0, 0, 8, "R8");
    run_op(4'd4, 1, 7, 1, 1, 8, "R4");   // move b elsewhere: max
    run_op(4'd8, 0, 0, 6, 0, 8, "R7");   // mask all ones
    run_op(4'd0, 0, 4, 0, 1, 3, "R9");   // short length simple
    run_op(4'd1, 1, 4, 1, 0, 3, "R9");   // short length density
    run_op(4'd9, 0, 0, 6, 0, 4, "R7");   // clear bits 0..3 only
    run_op(4'd0, 1, 2, 0, 0, 8, "R7");   // writes 4..7 only
    run_op(4'd9, 0, 0, 6, 0, 8, "R5");   // mask all zero
    run_op(4'd0, 1, 2, 0, 1, 8, "R5");   // density, empty mask
    run_op(4'd1, 0, 2, 0, 1, 8, "R3");   // simple, no writes
    run_op(4'd0, 0, 2, 0, 1, 0, "R10");  // zero length
    run_op(4'd8, 0, 0, 6, 0, 8, "R10");  // mask all ones again
    run_op(4'd6, 0, 2, 0, 1, 8, "R10");  // undefined opcode
    run_op(4'd0, 0, 3, 1, 1, 12, "R10"); // length clamped to 8
    run_op(4'd2, 1, 6, 0, 0, 15, "R10"); // clamp, density

    for (int r = 0; r < NR; r++)
      for (int i = 0; i < N; i++) begin
        checks++;
        if (rf[r][i] !== mrf[r][i]) begin
          fails++;
          $display("FAIL R3: reg %0d elem %0d = %h expected %h", r, i, rf[r][i], mrf[r][i]);
        end
      end
    finish_run();
  end
endmodule